// File: doc/BRIEF.md
# SMBus Host Status and Interrupt Sequencer

This block holds the host-side status byte of an SMBus-style host controller and drives that controller's single level-sensitive interrupt. A byte-transfer engine sends it one-cycle event pulses and qualifiers:
- a byte moved, with a flag marking the final byte of a block;
- the transfer finished;
- the transfer aborted with an error;
- the byte belongs to periodic heartbeat traffic.

Two steady inputs say whether the current transfer is a block transfer and whether the internal block buffer is in use. Software reads the status byte at offset 0 of a small register port. It clears bits by writing ones.

The byte-done flag gives a per-byte handshake for block transfers that run without the buffer. On such a transfer the completion flag is held back. It is raised only after software has acknowledged the final byte-done. The interrupt line first drops for one cycle. A block of n bytes therefore produces n+1 separate interrupt pulses. An error cancels a held-back completion.

Top module: `smb_host_status_seq`

## Requirements
- R1: After reset the status byte reads 0x00 and `irq` is low.
- R2: A write at offset 0 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: The byte-done flag (bit 7) is set one cycle after `ev_byte` when `xfer_block`=1, `buf_enable`=0 and `ev_heartbeat`=0. This includes the final byte (`ev_last`=1).
- R4: A byte pulse with `ev_heartbeat`=1 never sets byte-done.
- R5: With `buf_enable`=1, block byte pulses leave byte-done unchanged. `ev_done` then sets the done flag (bit 1) one cycle later.
- R6: A final block byte with the buffer off sets byte-done but not the done flag. The done flag is set only by a write that clears that byte-done. It appears two cycles after the write cycle, and in between all three status bits read 0.
- R7: An n-byte block transfer with the buffer off and software acknowledging every byte gives n+1 rising edges on `irq`.
- R8: A hardware set and a write-1 clear of the same bit in the same cycle leave the bit set.
- R9: `ev_error` sets the error flag (bit 2) one cycle later and cancels any held-back completion. A later clear of byte-done then does not set the done flag.
- R10: `irq` is high exactly when `irq_enable`=1 and any of bits 7, 2 or 1 is set. It stays high until all of them are cleared.
- R11: Writes at any offset other than 0 change nothing, and reads there return 0x00.
- R12: `ev_done` on a non-block transfer sets the done flag one cycle later. On a block transfer with the buffer off, `ev_done` alone sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data, ones clear bits |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| xfer_block | input | 1 | Current transfer is a block transfer |
| buf_enable | input | 1 | Internal block buffer in use |
| ev_byte | input | 1 | A byte was received or sent |
| ev_last | input | 1 | Qualifies `ev_byte` as the final block byte |
| ev_done | input | 1 | Transfer finished |
| ev_error | input | 1 | Transfer aborted with error |
| ev_heartbeat | input | 1 | Qualifies `ev_byte` as heartbeat traffic |
| irq_enable | input | 1 | Global interrupt enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: a 5-bit offset, byte-done at bit 7, error at bit 2, done at bit 1. With a 5-bit offset, writes and reads at the 31 other offsets can be tried. With the default bit positions, the random write data covers every mix of cleared and untouched bits. Long random runs switch between buffered, unbuffered and non-block transfers, so errors, heartbeat bytes and clears also land on the cycles where a completion is held back or about to fire.

// File: rtl/smbhs_pkg.sv
package smbhs_pkg;
  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WAIT = 2'd1,
    CS_FIRE = 2'd2
  } cmpl_st_e;

  localparam int unsigned STAT_W = 8;
endpackage

// File: rtl/smbhs_rst_sync.sv
module smbhs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/smbhs_evt_qual.sv
module smbhs_evt_qual (
  input  logic xfer_block,
  input  logic buf_enable,
  input  logic ev_byte,
  input  logic ev_last,
  input  logic ev_done,
  input  logic ev_heartbeat,
  output logic bd_set,
  output logic last_seen,
  output logic done_direct
);
  logic handshake_mode;

  always_comb begin
    handshake_mode = xfer_block & ~buf_enable;
    bd_set         = ev_byte & ~ev_heartbeat & handshake_mode;
    last_seen      = bd_set & ev_last;
    done_direct    = ev_done & ~handshake_mode;
  end
endmodule

// File: rtl/smbhs_cmpl_seq.sv
module smbhs_cmpl_seq
  import smbhs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     last_seen,
  input  logic     ack_taken,
  input  logic     abort,
  output cmpl_st_e state,
  output logic     fire
);
  cmpl_st_e st_q;
  cmpl_st_e st_d;
  logic     st_en;

  always_comb begin
    st_d = st_q;
    if (abort)                        st_d = CS_IDLE;
    else if (last_seen)               st_d = CS_WAIT;
    else if (st_q == CS_WAIT && ack_taken) st_d = CS_FIRE;
    else if (st_q == CS_FIRE)         st_d = CS_IDLE;
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= CS_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign state = st_q;
  assign fire  = (st_q == CS_FIRE) & ~abort;

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st_q == CS_IDLE));

  // R6
  fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_FIRE) |=> (st_q != CS_FIRE));
endmodule

// File: rtl/smbhs_stat_reg.sv
module smbhs_stat_reg #(
  parameter int unsigned       W        = 8,
  parameter logic [W-1:0]      IMPL_MSK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL_MSK[b]) begin : g_impl
      always_comb q_d[b] = set_vec[b] | (q_r[b] & ~clr_vec[b]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        q_r[b] <= 1'b0;
        else if (set_vec[b] | clr_vec[b])  q_r[b] <= q_d[b];
      end

      // R8
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[b] |=> q_r[b]);
    end else begin : g_rsvd
      always_comb q_d[b] = 1'b0;
      always_comb q_r[b] = 1'b0;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/smb_host_status_seq.sv
module smb_host_status_seq
  import smbhs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned STAT_OFS = 0,
  parameter int unsigned BD_BIT   = 7,
  parameter int unsigned ERR_BIT  = 2,
  parameter int unsigned DONE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              xfer_block,
  input  logic              buf_enable,
  input  logic              ev_byte,
  input  logic              ev_last,
  input  logic              ev_done,
  input  logic              ev_error,
  input  logic              ev_heartbeat,
  input  logic              irq_enable,
  output logic              irq
);
  localparam logic [STAT_W-1:0] IMPL_MSK =
    (STAT_W'(1) << BD_BIT) | (STAT_W'(1) << ERR_BIT) | (STAT_W'(1) << DONE_BIT);

  logic              rst_sync_n;
  logic              bd_set;
  logic              last_seen;
  logic              done_direct;
  logic              fire;
  logic              ack_taken;
  logic              sel_stat;
  cmpl_st_e          cmpl_state;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_q;

  smbhs_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  smbhs_evt_qual i_evt_qual (
    .xfer_block   (xfer_block),
    .buf_enable   (buf_enable),
    .ev_byte      (ev_byte),
    .ev_last      (ev_last),
    .ev_done      (ev_done),
    .ev_heartbeat (ev_heartbeat),
    .bd_set       (bd_set),
    .last_seen    (last_seen),
    .done_direct  (done_direct)
  );

  always_comb begin
    sel_stat  = (reg_addr == ADDR_W'(STAT_OFS));
    clr_vec   = (reg_wr && sel_stat) ? (reg_wdata & IMPL_MSK) : '0;
    ack_taken = clr_vec[BD_BIT] & stat_q[BD_BIT] & ~bd_set;
    set_vec           = '0;
    set_vec[BD_BIT]   = bd_set;
    set_vec[ERR_BIT]  = ev_error;
    set_vec[DONE_BIT] = done_direct | fire;
  end

  smbhs_cmpl_seq i_cmpl_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .last_seen (last_seen),
    .ack_taken (ack_taken),
    .abort     (ev_error),
    .state     (cmpl_state),
    .fire      (fire)
  );

  smbhs_stat_reg #(.W(STAT_W), .IMPL_MSK(IMPL_MSK)) i_stat_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .q       (stat_q)
  );

  assign reg_rdata = sel_stat ? stat_q : '0;
  assign irq       = irq_enable & (|stat_q);

  // R2
  zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && sel_stat && !reg_wdata[BD_BIT] && stat_q[BD_BIT]) |=> stat_q[BD_BIT]);

  // R4
  hb_no_bd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_heartbeat && !stat_q[BD_BIT]) |=> !stat_q[BD_BIT]);

  // R6
  fire_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmpl_state == CS_FIRE && !ev_error) |=> stat_q[DONE_BIT]);

  // R9
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_error |=> stat_q[ERR_BIT]);

  // R11
  other_ofs_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sel_stat && !ev_byte && !ev_done && !ev_error && cmpl_state == CS_IDLE)
      |=> $stable(stat_q));
endmodule

// File: tb/test_smb_host_status_seq.sv
`timescale 1ns/100ps
module test_smb_host_status_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       xfer_block = 1'b0, buf_enable = 1'b0;
  logic       ev_byte = 1'b0, ev_last = 1'b0, ev_done = 1'b0;
  logic       ev_error = 1'b0, ev_heartbeat = 1'b0, irq_enable = 1'b0;
  logic       irq;

  int n_chk = 0, n_fail = 0, rises = 0;
  bit prev_irq = 1'b0;
  bit done_flag = 1'b0;
  bit m_bd, m_err, m_dn;
  int m_pend;

  always #2 clk = ~clk;

  smb_host_status_seq i_smb_host_status_seq (.*);

  function automatic logic [7:0] exp_stat();
    return {m_bd, 4'b0, m_err, m_dn, 1'b0};
  endfunction

  function automatic void model_step();
    logic [7:0] clr;
    bit hs, bds, fire, nbd, nerr, ndn;
    int npend;
    clr  = (reg_wr && reg_addr == 5'd0) ? reg_wdata : 8'h00;
    hs   = xfer_block && !buf_enable;
    bds  = ev_byte && hs && !ev_heartbeat;
    fire = (m_pend == 2) && !ev_error;
    nbd  = bds || (m_bd && !clr[7]);
    nerr = ev_error || (m_err && !clr[2]);
    ndn  = fire || (ev_done && !hs) || (m_dn && !clr[1]);
    npend = m_pend;
    if (ev_error) npend = 0;
    else if (bds && ev_last) npend = 1;
    else if (m_pend == 1 && m_bd && clr[7] && !bds) npend = 2;
    else if (m_pend == 2) npend = 0;
    m_bd = nbd; m_err = nerr; m_dn = ndn; m_pend = npend;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [4:0] sv;
    sv = reg_addr;
    reg_addr = 5'd0;
    #0.5;
    chk({tag, " status"}, reg_rdata, exp_stat());
    chk({tag, " irq R10"}, {7'b0, irq}, {7'b0, irq_enable & (m_bd | m_err | m_dn)});
    reg_addr = sv;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    if (irq && !prev_irq) rises++;
    prev_irq = irq;
    check_all(tag);
  endtask

  task automatic idle();
    reg_wr = 0; ev_byte = 0; ev_last = 0; ev_done = 0;
    ev_error = 0; ev_heartbeat = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic wr_stat(input logic [7:0] d, input string tag);
    reg_wr = 1; reg_addr = 0; reg_wdata = d;
    tick(tag);
    idle();
  endtask

  task automatic byte_ev(input bit last, input bit hb, input string tag);
    ev_byte = 1; ev_last = last; ev_heartbeat = hb;
    tick(tag);
    idle();
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_bd = 0; m_err = 0; m_dn = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    irq_enable = 1;
    check_all("R1 reset");

    // R3, R4: unbuffered block bytes, heartbeat ignored
    xfer_block = 1; buf_enable = 0;
    byte_ev(0, 1, "R4 heartbeat");
    chk("R4 no byte-done", reg_rdata, 8'h00);
    byte_ev(0, 0, "R3 byte");
    chk("R3 byte-done set", reg_rdata, 8'h80);
    // R2: write zero keeps, write one clears
    wr_stat(8'h7F, "R2 zero write");
    chk("R2 kept", reg_rdata, 8'h80);
    wr_stat(8'h80, "R2 clear");
    chk("R2 cleared", reg_rdata, 8'h00);

    // R8: set and clear together
    byte_ev(0, 0, "R8 pre");
    ev_byte = 1; reg_wr = 1; reg_wdata = 8'h80;
    tick("R8 collide");
    idle();
    chk("R8 set wins", reg_rdata, 8'h80);
    wr_stat(8'h80, "R8 cleanup");

    // R6, R7: three-byte block, n+1 rising edges
    rises = 0;
    for (int i = 0; i < 3; i++) begin
      byte_ev(i == 2, 0, "R7 byte");
      tick("R7 wait");
      ev_done = (i == 2);
      tick("R12 done ignored in handshake");
      idle();
      wr_stat(8'h80, "R7 ack");
      if (i == 2) begin
        chk("R6 gap status", reg_rdata, 8'h00);
        chk("R6 gap irq", {7'b0, irq}, 8'h00);
      end
      tick("R6 idle");
    end
    chk("R6 done flag", reg_rdata, 8'h02);
    wr_stat(8'h02, "R10 clear done");
    chk("R7 irq edge count", 8'(rises), 8'd4);
    chk("R10 irq low after clear", {7'b0, irq}, 8'h00);

    // R9: error cancels held completion
    byte_ev(1, 0, "R9 last byte");
    ev_error = 1;
    tick("R9 error");
    idle();
    chk("R9 error flag", reg_rdata, 8'h84);
    wr_stat(8'h80, "R9 ack");
    tick("R9 after");
    chk("R9 no done", reg_rdata, 8'h04);
    irq_enable = 0;
    tick("R10 gated");
    chk("R10 irq gated", {7'b0, irq}, 8'h00);
    irq_enable = 1;
    wr_stat(8'h04, "R9 clear err");

    // R5: buffered block
    buf_enable = 1;
    byte_ev(1, 0, "R5 buffered byte");
    chk("R5 no byte-done", reg_rdata, 8'h00);
    ev_done = 1;
    tick("R5 done");
    idle();
    chk("R5 done flag", reg_rdata, 8'h02);
    wr_stat(8'h02, "R5 clear");

    // R12: non-block done
    xfer_block = 0; buf_enable = 0;
    ev_done = 1;
    tick("R12 done");
    idle();
    chk("R12 done flag", reg_rdata, 8'h02);

    // R11: other offset
    reg_wr = 1; reg_addr = 5'd4; reg_wdata = 8'hFF;
    #0.5;
    chk("R11 read other", reg_rdata, 8'h00);
    tick("R11 write other");
    idle();
    chk("R11 unchanged", reg_rdata, 8'h02);
    wr_stat(8'h02, "R11 cleanup");

    // random phase
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < 4000; c++) begin
      if (c % 50 == 0) begin
        xfer_block = $urandom_range(0, 3) != 0;
        buf_enable = $urandom_range(0, 3) == 0;
      end
      ev_byte      = $urandom_range(0, 3) == 0;
      ev_last      = $urandom_range(0, 2) == 0;
      ev_heartbeat = $urandom_range(0, 5) == 0;
      ev_done      = $urandom_range(0, 9) == 0;
      ev_error     = $urandom_range(0, 29) == 0;
      irq_enable   = $urandom_range(0, 7) != 0;
      reg_wr       = $urandom_range(0, 2) == 0;
      reg_addr     = ($urandom_range(0, 4) == 0) ? 5'($urandom_range(1, 31)) : 5'd0;
      reg_wdata    = 8'($urandom);
      tick("R2 R3 R6 R8 R9 random");
    end
    idle();

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule